// File: doc/BRIEF.md
# NAND Hamming ECC Accumulator

This block sits beside the data register of a NAND flash controller and watches every byte that crosses the flash data path. While it is told to accumulate, each byte folds into a single-error-correcting Hamming code that covers one 256-byte chunk. After 256 bytes it moves on to a second chunk, so a 512-byte page leaves behind two three-byte codes.

A two-bit field inside the controller's mode register sequences the engine. Software first writes the clear code, then off, then accumulate, and moves the page. To collect the result it selects read-out. From that point, each read of the data register returns the next stored ECC byte in place of flash data. The block drives the select for that read mux and the byte itself. Comparing codes and fixing a flipped bit in memory are left to software.

Top module: `nand_hecc_accum`

## Requirements
- R1: After reset, read-out returns 0xFF for all six ECC bytes, and the read-out select is low while the mode field is not read-out.
- R2: The mode field is bits 6:5 of the mode-register input: 11 clear, 00 off, 01 accumulate, 10 read-out. The other bits of that input have no effect. The read-out select is high exactly when the field is 10.
- R3: In accumulate mode, each valid data byte at position i (0..255) of its chunk XORs the byte's parity into line-parity bit 2k+1 when bit k of i is 1, and into bit 2k when it is 0, for k = 0..7. Stored code byte 0 is the inverse of line parities 7:0, and stored byte 1 is the inverse of line parities 15:8.
- R4: Column parity bit 2j+1 (2j) is the XOR, over all bytes of the chunk, of the data bits whose bit position has bit j set (clear), for j = 0..2. Stored byte 2 holds the inverted column parities in bits 7:2 and ones in bits 1:0.
- R5: A byte counter selects the chunk. Bytes 0..255 feed chunk 0 and bytes 256..511 feed chunk 1. The counter wraps at 512, and further bytes XOR again into chunk 0.
- R6: In off mode, data-path bytes are ignored. The counter and the stored codes keep their values.
- R7: The clear code zeroes both chunks and the counter, so every ECC byte reads 0xFF. A data byte presented in the same cycle as clear is dropped.
- R8: In read-out mode, successive reads return chunk 0's stored byte 1, byte 0, byte 2, then the same for chunk 1, then wrap back to chunk 0.
- R9: Any cycle with the field not at read-out resets the read pointer to chunk 0's first returned byte.
- R10: Flipping any single data bit of a chunk changes exactly one bit of each of the 11 parity pairs. The odd line bits then spell the byte index and the odd column bits spell the bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_mode | input | 8 | Controller mode register value; bits 6:5 are the ECC field |
| xfer_valid | input | 1 | A byte crosses the flash data path this cycle |
| xfer_byte | input | 8 | The byte on the data path |
| dreg_rd | input | 1 | The data register is read this cycle |
| ecc_sel | output | 1 | Data register reads return ECC bytes |
| ecc_byte | output | 8 | ECC byte returned by the current read |

## Verification
Two functions can fall in the same cycle: a data-path byte strobe and a mode change to the clear code. The bench provokes this by setting the field to clear in the very cycle it asserts a byte. Clear must win, so a read-out of all six bytes after the sequence has to show 0xFF everywhere. The second collision is a data-register read in the last read-out cycle before the field leaves read-out. This is judged by the first read after re-entry returning chunk 0's first byte again.

// File: rtl/nand_hecc_pkg.sv
package nand_hecc_pkg;

   typedef enum logic [1:0] {
      ECC_OFF   = 2'b00,
      ECC_ACCUM = 2'b01,
      ECC_DUMP  = 2'b10,
      ECC_CLEAR = 2'b11
   } ecc_mode_e;

   localparam int ECC_FIELD_W = 2;
   localparam int CODE_BYTES  = 3;

endpackage

// File: rtl/nand_hecc_lane.sv
module nand_hecc_lane #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            clr,
   input  logic                            upd,
   input  logic [IDX_W-1:0]                idx,
   input  logic [DATA_W-1:0]               din,
   output logic [3*DATA_W-1:0]             code
);
   localparam int LP_W  = 2 * IDX_W;
   localparam int CPB   = $clog2(DATA_W);
   localparam int CP_W  = 2 * CPB;
   localparam int PAD_W = 2 * DATA_W;

   function automatic logic [DATA_W-1:0] pos_mask(input int j, input bit hi);
      logic [DATA_W-1:0] m;
      for (int b = 0; b < DATA_W; b++) begin
         m[b] = ((((b >> j) & 1) != 0) == hi);
      end
      return m;
   endfunction

   logic [LP_W-1:0]   lp_q;
   logic [LP_W-1:0]   lp_flip;
   logic [DATA_W-1:0] col_q;
   logic [CP_W-1:0]   cp;
   logic [PAD_W-1:0]  lp_pad;
   logic              row_par;

   assign row_par = ^din;

   for (genvar k = 0; k < IDX_W; k++) begin : g_line
      assign lp_flip[2*k+1] = row_par &  idx[k];
      assign lp_flip[2*k]   = row_par & ~idx[k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         lp_q  <= '0;
         col_q <= '0;
      end else if (upd) begin
         lp_q  <= lp_q ^ lp_flip;
         col_q <= col_q ^ din;
      end
   end

   for (genvar j = 0; j < CPB; j++) begin : g_col
      localparam logic [DATA_W-1:0] M_HI = pos_mask(j, 1'b1);
      localparam logic [DATA_W-1:0] M_LO = pos_mask(j, 1'b0);
      assign cp[2*j+1] = ^(col_q & M_HI);
      assign cp[2*j]   = ^(col_q & M_LO);
   end

   if (LP_W == PAD_W) begin : g_full
      assign lp_pad = lp_q;
   end else begin : g_short
      assign lp_pad = {{(PAD_W-LP_W){1'b0}}, lp_q};
   end

   assign code = {~cp, {(DATA_W-CP_W){1'b1}}, ~lp_pad};

endmodule

// File: rtl/nand_hecc_dump.sv
module nand_hecc_dump #(
   parameter int DATA_W     = 8,
   parameter int NUM_CHUNKS = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              active,
   input  logic                              step,
   input  logic [NUM_CHUNKS*3*DATA_W-1:0]    codes,
   output logic [1:0]                        sub_q,
   output logic [$clog2(NUM_CHUNKS)-1:0]     chk_q,
   output logic [DATA_W-1:0]                 byte_out
);
   localparam int CH_W   = $clog2(NUM_CHUNKS);
   localparam int CODE_W = 3 * DATA_W;
   localparam logic [CH_W-1:0] LAST_CHK = CH_W'(NUM_CHUNKS - 1);

   logic [CODE_W-1:0] cur;

   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         sub_q <= 2'd0;
         chk_q <= '0;
      end else if (step) begin
         if (sub_q == 2'd2) begin
            sub_q <= 2'd0;
            chk_q <= (chk_q == LAST_CHK) ? '0 : chk_q + 1'b1;
         end else begin
            sub_q <= sub_q + 2'd1;
         end
      end
   end

   assign cur = codes[int'(chk_q)*CODE_W +: CODE_W];

   always_comb begin
      unique case (sub_q)
         2'd0:    byte_out = cur[2*DATA_W-1:DATA_W];
         2'd1:    byte_out = cur[DATA_W-1:0];
         default: byte_out = cur[3*DATA_W-1:2*DATA_W];
      endcase
   end

endmodule

// File: rtl/nand_hecc_accum.sv
module nand_hecc_accum
   import nand_hecc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CHUNK_BYTES = 256,
   parameter int NUM_CHUNKS  = 2,
   parameter int CTRL_W      = 8,
   parameter int MODE_LSB    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] ctrl_mode,
   input  logic              xfer_valid,
   input  logic [DATA_W-1:0] xfer_byte,
   input  logic              dreg_rd,
   output logic              ecc_sel,
   output logic [DATA_W-1:0] ecc_byte
);
   localparam int IDX_W  = $clog2(CHUNK_BYTES);
   localparam int CH_W   = $clog2(NUM_CHUNKS);
   localparam int CNT_W  = IDX_W + CH_W;
   localparam int CODE_W = CODE_BYTES * DATA_W;

   if (DATA_W != 8) begin : g_bad_width
      $error("nand_hecc_accum: DATA_W must be 8");
   end
   if ((CHUNK_BYTES < 2) || (CHUNK_BYTES > 256) || ((1 << IDX_W) != CHUNK_BYTES)) begin : g_bad_chunk
      $error("nand_hecc_accum: CHUNK_BYTES must be a power of two up to 256");
   end
   if ((NUM_CHUNKS < 2) || ((1 << CH_W) != NUM_CHUNKS)) begin : g_bad_count
      $error("nand_hecc_accum: NUM_CHUNKS must be a power of two of at least 2");
   end
   if (MODE_LSB + ECC_FIELD_W > CTRL_W) begin : g_bad_field
      $error("nand_hecc_accum: mode field outside the control word");
   end

   ecc_mode_e                 mode;
   logic                      clr;
   logic                      acc_en;
   logic [CNT_W-1:0]          byte_cnt;
   logic [CH_W-1:0]           chunk_idx;
   logic [NUM_CHUNKS*CODE_W-1:0] codes;
   logic [1:0]                sub_q;
   logic [CH_W-1:0]           chk_q;

   assign mode      = ecc_mode_e'(ctrl_mode[MODE_LSB +: ECC_FIELD_W]);
   assign clr       = (mode == ECC_CLEAR);
   assign acc_en    = (mode == ECC_ACCUM) && xfer_valid;
   assign ecc_sel   = (mode == ECC_DUMP);
   assign chunk_idx = byte_cnt[CNT_W-1:IDX_W];

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         byte_cnt <= '0;
      end else if (acc_en) begin
         byte_cnt <= byte_cnt + 1'b1;
      end
   end

   for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_lane
      nand_hecc_lane #(
         .DATA_W (DATA_W),
         .IDX_W  (IDX_W)
      ) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr),
         .upd   (acc_en && (chunk_idx == CH_W'(g))),
         .idx   (byte_cnt[IDX_W-1:0]),
         .din   (xfer_byte),
         .code  (codes[g*CODE_W +: CODE_W])
      );
   end

   nand_hecc_dump #(
      .DATA_W     (DATA_W),
      .NUM_CHUNKS (NUM_CHUNKS)
   ) u_dump (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (ecc_sel),
      .step     (dreg_rd),
      .codes    (codes),
      .sub_q    (sub_q),
      .chk_q    (chk_q),
      .byte_out (ecc_byte)
   );

endmodule

// File: rtl/nand_hecc_accum_chk.sv
module nand_hecc_accum_chk #(
   parameter int CH_W  = 1,
   parameter int CNT_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode,
   input logic             xfer_valid,
   input logic             dreg_rd,
   input logic [7:0]       ecc_byte,
   input logic [1:0]       sub_q,
   input logic [CH_W-1:0]  chk_q,
   input logic [CNT_W-1:0] byte_cnt
);
   localparam logic [CH_W-1:0] LAST_CHK = '1;

   AST_PTR_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'b10) |=> (sub_q == 2'd0 && chk_q == '0)); // R9

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && dreg_rd && sub_q != 2'd2) |=>
      (sub_q == 2'($past(sub_q) + 2'd1) && $stable(chk_q))); // R8

   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && dreg_rd && sub_q == 2'd2 && chk_q == LAST_CHK) |=>
      (sub_q == 2'd0 && chk_q == '0)); // R8

   AST_CLR_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11) |=> (ecc_byte == 8'hFF)); // R7

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && xfer_valid) |=>
      (byte_cnt == CNT_W'($past(byte_cnt) + 1'b1))); // R5

   AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |=> $stable(byte_cnt)); // R6

endmodule

bind nand_hecc_accum nand_hecc_accum_chk #(
   .CH_W  (CH_W),
   .CNT_W (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode       (ctrl_mode[MODE_LSB +: 2]),
   .xfer_valid (xfer_valid),
   .dreg_rd    (dreg_rd),
   .ecc_byte   (ecc_byte),
   .sub_q      (sub_q),
   .chk_q      (chk_q),
   .byte_cnt   (byte_cnt)
);

// File: tb/tb_nand_hecc_accum.sv
module tb_nand_hecc_accum;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ctrl_mode = 8'h90;
   logic       xfer_valid = 1'b0;
   logic [7:0] xfer_byte = 8'h00;
   logic       dreg_rd = 1'b0;
   logic       ecc_sel;
   logic [7:0] ecc_byte;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] pg [0:1023];

   always #10 clk = ~clk;

   nand_hecc_accum dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_mode  (ctrl_mode),
      .xfer_valid (xfer_valid),
      .xfer_byte  (xfer_byte),
      .dreg_rd    (dreg_rd),
      .ecc_sel    (ecc_sel),
      .ecc_byte   (ecc_byte)
   );

   function automatic logic [23:0] ref_ecc(input int off);
      logic [15:0] lp = '0;
      logic [5:0]  cp = '0;
      logic        p;
      for (int i = 0; i < 256; i++) begin
         p = ^pg[off+i];
         for (int k = 0; k < 8; k++) begin
            if (((i >> k) & 1) != 0) lp[2*k+1] ^= p;
            else                     lp[2*k]   ^= p;
         end
         for (int b = 0; b < 8; b++) begin
            for (int j = 0; j < 3; j++) begin
               if (((b >> j) & 1) != 0) cp[2*j+1] ^= pg[off+i][b];
               else                     cp[2*j]   ^= pg[off+i][b];
            end
         end
      end
      return {~cp, 2'b11, ~lp[15:8], ~lp[7:0]};
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic set_mode(input logic [1:0] m);
      @(negedge clk);
      ctrl_mode = (8'h91 & ~8'h60) | {1'b0, m, 5'b0};
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      xfer_valid = 1'b1;
      xfer_byte  = b;
      @(negedge clk);
      xfer_valid = 1'b0;
   endtask

   task automatic feed(input int off, input int n);
      for (int i = 0; i < n; i++) send_byte(pg[off+i]);
   endtask

   task automatic read_exp(input logic [7:0] e, input string tag);
      @(negedge clk);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      dreg_rd = 1'b1;
      @(negedge clk);
      dreg_rd = 1'b0;
   endtask

   task automatic read_code(input logic [23:0] c, input string tag);
      read_exp(c[15:8], tag);
      read_exp(c[7:0], tag);
      read_exp(c[23:16], tag);
   endtask

   task automatic start_acc();
      set_mode(2'b11);
      set_mode(2'b00);
      set_mode(2'b01);
   endtask

   task automatic to_dump();
      set_mode(2'b00);
      set_mode(2'b10);
   endtask

   // monitor: pops an expected byte for every data-register read
   always @(negedge clk) begin
      #2;
      if (dreg_rd) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "scoreboard underflow", ecc_byte, 0);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(ecc_byte === e && ecc_sel === 1'b1, t, ecc_byte, e);
         end
      end
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [23:0] c0, c1, ca, cb, syn;
      int          bidx, bpos;
      for (int i = 0; i < 1024; i++) pg[i] = 8'((i * 37 + 11) ^ (i >> 3));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      #2 check(ecc_sel === 1'b0, "R1 select low after reset", ecc_sel, 0);
      set_mode(2'b10);
      for (int i = 0; i < 6; i++) read_exp(8'hFF, "R1 erased code after reset");

      // R2: field decode, other bits of the mode word set
      for (int m = 0; m < 4; m++) begin
         set_mode(2'(m));
         #2 check(ecc_sel === (m == 2), "R2 select per field value", ecc_sel, (m == 2));
      end

      // R3 R4 R5 R8: one page over two chunks
      c0 = ref_ecc(0);
      c1 = ref_ecc(256);
      start_acc();
      feed(0, 512);
      to_dump();
      read_code(c0, "R3 R4 R8 chunk0 order");
      read_code(c1, "R5 R8 chunk1 order");
      read_exp(c0[15:8], "R8 pointer wraps to chunk0");

      // R9: last read in the cycle before leaving read-out
      @(negedge clk);
      exp_q.push_back(c0[7:0]);
      tag_q.push_back("R9 read before leaving");
      dreg_rd = 1'b1;
      @(negedge clk);
      dreg_rd = 1'b0;
      ctrl_mode = 8'h91 & ~8'h60;
      set_mode(2'b10);
      read_exp(c0[15:8], "R9 pointer home after re-entry");

      // R6: off mode ignores bytes
      set_mode(2'b00);
      for (int i = 0; i < 10; i++) send_byte(8'(i * 13 + 1));
      set_mode(2'b10);
      read_code(c0, "R6 chunk0 held in off mode");
      read_code(c1, "R6 chunk1 held in off mode");

      // R7: clear wins over a byte in the same cycle
      @(negedge clk);
      ctrl_mode = (8'h91 & ~8'h60) | 8'h60;
      xfer_valid = 1'b1;
      xfer_byte = 8'h01;
      @(negedge clk);
      xfer_valid = 1'b0;
      to_dump();
      for (int i = 0; i < 6; i++) read_exp(8'hFF, "R7 clear drops simultaneous byte");

      // R5: counter wrap at 512 returns to chunk 0
      for (int i = 0; i < 256; i++) pg[768+i] = pg[i] ^ pg[512+i];
      ca = ref_ecc(768);
      start_acc();
      feed(0, 512);
      feed(512, 256);
      to_dump();
      read_code(ca, "R5 wrap folds into chunk0");
      read_code(c1, "R5 chunk1 untouched after wrap");

      // R10: single flipped bit
      cb = ref_ecc(0);
      pg[0 + 77] = pg[77] ^ 8'h20;
      ca = ref_ecc(0);
      start_acc();
      feed(0, 256);
      to_dump();
      read_code(ca, "R10 code with flipped bit");
      pg[77] = pg[77] ^ 8'h20;
      syn = ca ^ cb;
      check($countones({syn[23:18], syn[15:0]}) == 11, "R10 eleven syndrome bits",
            $countones({syn[23:18], syn[15:0]}), 11);
      bidx = 0;
      for (int k = 0; k < 8; k++) if (syn[2*k+1]) bidx |= (1 << k);
      bpos = 0;
      for (int j = 0; j < 3; j++) if (syn[18+2*j+1]) bpos |= (1 << j);
      check(bidx == 77, "R10 syndrome byte index", bidx, 77);
      check(bpos == 5, "R10 syndrome bit position", bpos, 5);

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule